// File: doc/BRIEF.md
# Mode-Remapping Priority Interrupt Controller

This block arbitrates eight interrupt request lines for a machine with two processors. Requests arrive either as hardware sensor pulses or as software set strobes. Each one is latched into a pending register and stays queued until a processor acknowledges it. A per-line mask keeps a request queued but hides it from arbitration. Line k stands for priority level k+1, so line 0 is level 1, and line 7 is a spare that ranks last.

Three presentation ports carry the winners. Port 1 feeds the primary processor. Ports 2 and 3 both feed the secondary processor. A survive input selects between two rankings and two routing schemes:

- **Normal mode:** both processors work concurrently. Port 1 takes the most urgent eligible line and port 2 takes the next one. Port 3 stays idle.
- **Survive mode:** the ranking is reshuffled. Port 1 accepts only level 1, and port 3 carries every other level to the secondary processor. Port 2 loads nothing new.

Level 1 always goes to the primary processor. If port 1 is showing something less urgent when level 1 becomes eligible, level 1 displaces it.

Each port holds a valid flag and a three-bit level code until its acknowledge. The acknowledge clears only the pending bit of the code being shown.

Top module: `remap_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `hw_req[k]` or `sw_set[k]` marks line k pending. A free, permitted port presents it with level code k after the second rising edge following the pulse. The line stays pending until that presentation is acknowledged.
- R2: While `mask[k]` is 1, pending line k is never newly presented, but it stays queued. One rising edge after the mask bit returns to 0, a free port presents it.
- R3: In normal mode (`survive`=0), a lower code ranks higher. An idle port 1 loads the top-ranked eligible line. An idle port 2 loads the top-ranked eligible line other than code 0 and other than the line port 1 loads on the same edge. Port 3 never loads.
- R4: In survive mode, the ranking from most to least urgent is codes 0,1,5,6,3,4,2,7. Port 1 loads only code 0. Port 3 loads the top-ranked eligible line other than code 0. Port 2 never loads.
- R5: Code 0 is never presented on ports 2 or 3. If code 0 is eligible while port 1 presents another code, port 1 switches to code 0 on the next edge. The displaced line stays pending and returns to arbitration.
- R6: A port keeps its valid flag and code unchanged until its acknowledge, apart from the R5 switch. No code is presented on two ports at once.
- R7: An acknowledge on a valid port drops that port's valid flag on the next edge and clears only that code's pending bit. An acknowledge on an idle port has no effect. A set that arrives on the same edge as the clear keeps the line pending.
- R8: Spare line 7 ranks below every other line in both modes.
- R9: Changing `survive` never withdraws a level already presented on any port. That level stays shown until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| survive | input | 1 | 1 selects survive ranking and routing |
| hw_req | input | 8 | Hardware request pulses, one per line |
| sw_set | input | 8 | Software request strobes, one per line |
| mask | input | 8 | 1 hides the line from arbitration |
| ack1 | input | 1 | Acknowledge of port 1 |
| ack2 | input | 1 | Acknowledge of port 2 |
| ack3 | input | 1 | Acknowledge of port 3 |
| p1_valid | output | 1 | Port 1 (primary) presents a level |
| p1_level | output | 3 | Port 1 level code (level minus one) |
| p2_valid | output | 1 | Port 2 (secondary, normal mode) presents a level |
| p2_level | output | 3 | Port 2 level code |
| p3_valid | output | 1 | Port 3 (secondary, survive mode) presents a level |
| p3_level | output | 3 | Port 3 level code |

## Verification
Timing from each stimulus to its result:

- **New request:** it becomes pending on the first edge and appears on a port at the second. The bench drives every pulse after a falling edge and samples after two further falling edges. One check also confirms that nothing is shown after only one edge.
- **Acknowledge:** it empties its port on the next edge. The next queued line appears one edge after that, so those checks sample one and two edges after the acknowledge.
- **Level-1 preemption and unmasking:** both act on the edge after the line becomes eligible, and are sampled there.
- **Mode changes:** these are checked two edges later, so that any wrongful reload or withdrawal would already be visible.

// File: rtl/remap_irq_pkg.sv
package remap_irq_pkg;

  localparam int NREQ_DEF = 8;
  localparam int NPORT    = 3;

  // Urgency rank of a line: 0 is most urgent.
  // Normal mode ranks by code; survive mode moves the movement-related
  // lines (codes 5,6) up and the command-listening line (code 2) down.
  function automatic int lvl_rank(input int code, input logic surv);
    int r;
    r = code;
    if (surv) begin
      case (code)
        2:       r = 6;
        3:       r = 4;
        4:       r = 5;
        5:       r = 2;
        6:       r = 3;
        default: r = code;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/remap_irq_pending.sv
module remap_irq_pending #(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] set_i,
  input  logic [NREQ-1:0] clr_i,
  output logic [NREQ-1:0] pend_o
);

  // A set arriving on the same edge as a clear wins, so no request is lost.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

endmodule

// File: rtl/remap_irq_select.sv
module remap_irq_select
  import remap_irq_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int CW   = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] cand_i,
  input  logic            surv_i,
  output logic            found_o,
  output logic [CW-1:0]   code_o
);

  always_comb begin
    int best;
    best    = NREQ;
    found_o = 1'b0;
    code_o  = '0;
    for (int c = 0; c < NREQ; c++) begin
      if (cand_i[c] && (lvl_rank(c, surv_i) < best)) begin
        best    = lvl_rank(c, surv_i);
        found_o = 1'b1;
        code_o  = CW'(c);
      end
    end
  end

endmodule

// File: rtl/remap_irq_slot.sv
module remap_irq_slot #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_code_i,
  input  logic          preempt_i,
  input  logic          ack_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o
);

  // Acknowledge first, then the level-1 switch, then a fresh load into an idle slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (ack_i && valid_o) begin
      valid_o <= 1'b0;
    end else if (preempt_i) begin
      valid_o <= 1'b1;
      code_o  <= '0;
    end else if (load_i && !valid_o) begin
      valid_o <= 1'b1;
      code_o  <= load_code_i;
    end
  end

endmodule

// File: rtl/remap_irq_ctrl.sv
module remap_irq_ctrl
  import remap_irq_pkg::*;
#(
  parameter int NREQ = remap_irq_pkg::NREQ_DEF,
  parameter int CW   = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            survive,
  input  logic [NREQ-1:0] hw_req,
  input  logic [NREQ-1:0] sw_set,
  input  logic [NREQ-1:0] mask,
  input  logic            ack1,
  input  logic            ack2,
  input  logic            ack3,
  output logic            p1_valid,
  output logic [CW-1:0]   p1_level,
  output logic            p2_valid,
  output logic [CW-1:0]   p2_level,
  output logic            p3_valid,
  output logic [CW-1:0]   p3_level
);

  localparam logic [NREQ-1:0] TOP_LINE = NREQ'(1);

  logic [NREQ-1:0]  pend, clr_vec, inflight, elig;
  logic [NREQ-1:0]  cand_p1, cand_p2, cand_p3, take_p1;
  logic [NPORT-1:0] slot_valid, slot_ack, slot_load, sel_found;
  logic [CW-1:0]    slot_code [NPORT];
  logic [CW-1:0]    sel_code  [NPORT];
  logic             p1_preempt;

  remap_irq_pending #(.NREQ(NREQ)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hw_req | sw_set),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  assign slot_ack = {ack3, ack2, ack1};

  // Lines shown on a port, and lines cleared by an acknowledge this edge.
  always_comb begin
    inflight = '0;
    clr_vec  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (slot_valid[p]) inflight[slot_code[p]] = 1'b1;
      if (slot_valid[p] && slot_ack[p]) clr_vec[slot_code[p]] = 1'b1;
    end
  end

  assign elig = pend & ~mask & ~inflight;

  // Candidate sets per port; port 1 takes only level 1 in survive mode.
  assign cand_p1 = survive ? (elig & TOP_LINE) : elig;
  assign take_p1 = slot_load[0] ? (TOP_LINE << sel_code[0]) : '0;
  assign cand_p2 = elig & ~TOP_LINE & ~take_p1;
  assign cand_p3 = elig & ~TOP_LINE;

  remap_irq_select #(.NREQ(NREQ), .CW(CW)) u_sel1 (
    .cand_i (cand_p1), .surv_i (survive),
    .found_o(sel_found[0]), .code_o (sel_code[0])
  );
  remap_irq_select #(.NREQ(NREQ), .CW(CW)) u_sel2 (
    .cand_i (cand_p2), .surv_i (survive),
    .found_o(sel_found[1]), .code_o (sel_code[1])
  );
  remap_irq_select #(.NREQ(NREQ), .CW(CW)) u_sel3 (
    .cand_i (cand_p3), .surv_i (survive),
    .found_o(sel_found[2]), .code_o (sel_code[2])
  );

  assign slot_load[0] = !slot_valid[0] && sel_found[0];
  assign slot_load[1] = !slot_valid[1] && !survive && sel_found[1];
  assign slot_load[2] = !slot_valid[2] &&  survive && sel_found[2];

  // Level 1 displaces a less urgent level on the primary port.
  assign p1_preempt = slot_valid[0] && (slot_code[0] != '0) && elig[0];

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    remap_irq_slot #(.CW(CW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (slot_load[p]),
      .load_code_i(sel_code[p]),
      .preempt_i  ((p == 0) ? p1_preempt : 1'b0),
      .ack_i      (slot_ack[p]),
      .valid_o    (slot_valid[p]),
      .code_o     (slot_code[p])
    );
  end

  assign p1_valid = slot_valid[0];
  assign p1_level = slot_code[0];
  assign p2_valid = slot_valid[1];
  assign p2_level = slot_code[1];
  assign p3_valid = slot_valid[2];
  assign p3_level = slot_code[2];

endmodule

// File: rtl/remap_irq_ctrl_chk.sv
module remap_irq_ctrl_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          survive,
  input logic          ack1,
  input logic          ack2,
  input logic          ack3,
  input logic          p1_preempt,
  input logic          p1_valid,
  input logic [CW-1:0] p1_level,
  input logic          p2_valid,
  input logic [CW-1:0] p2_level,
  input logic          p3_valid,
  input logic [CW-1:0] p3_level
);

  // R3
  p2_load_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p2_valid) |-> !$past(survive));

  // R4
  p3_load_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p3_valid) |-> $past(survive));

  // R4
  p1_survive_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(p1_valid) && $past(survive)) |-> (p1_level == '0));

  // R5
  top_on_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_valid |-> p2_level != '0) and (p3_valid |-> p3_level != '0));

  // R6
  p2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p2_valid) && !$past(ack2)) |-> (p2_valid && $stable(p2_level)));

  // R6
  p3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p3_valid) && !$past(ack3)) |-> (p3_valid && $stable(p3_level)));

  // R6
  p1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p1_valid) && !$past(ack1) && !$past(p1_preempt))
      |-> (p1_valid && $stable(p1_level)));

  // R6
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1_valid && p2_valid) |-> p1_level != p2_level) and
    ((p1_valid && p3_valid) |-> p1_level != p3_level) and
    ((p2_valid && p3_valid) |-> p2_level != p3_level));

endmodule

bind remap_irq_ctrl remap_irq_ctrl_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .survive   (survive),
  .ack1      (ack1),
  .ack2      (ack2),
  .ack3      (ack3),
  .p1_preempt(p1_preempt),
  .p1_valid  (p1_valid),
  .p1_level  (p1_level),
  .p2_valid  (p2_valid),
  .p2_level  (p2_level),
  .p3_valid  (p3_valid),
  .p3_level  (p3_level)
);

// File: tb/remap_irq_ctrl_test.sv
`timescale 1ns/1ps
module remap_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       survive = 1'b0;
  logic [7:0] hw_req = '0, sw_set = '0, mask = '0;
  logic       ack1 = 1'b0, ack2 = 1'b0, ack3 = 1'b0;
  logic       p1_valid, p2_valid, p3_valid;
  logic [2:0] p1_level, p2_level, p3_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  remap_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .survive(survive),
    .hw_req(hw_req), .sw_set(sw_set), .mask(mask),
    .ack1(ack1), .ack2(ack2), .ack3(ack3),
    .p1_valid(p1_valid), .p1_level(p1_level),
    .p2_valid(p2_valid), .p2_level(p2_level),
    .p3_valid(p3_valid), .p3_level(p3_level)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expect port `port` to show (ev, el); level ignored when ev is 0.
  task automatic expect_port(input int port, input bit ev, input int el, input string tag);
    logic v; logic [2:0] l;
    case (port)
      1: begin v = p1_valid; l = p1_level; end
      2: begin v = p2_valid; l = p2_level; end
      default: begin v = p3_valid; l = p3_level; end
    endcase
    n_chk++;
    if (v !== ev || (ev && l !== 3'(el))) begin
      n_bad++;
      $display("FAIL %s port%0d: got valid=%0d level=%0d, expected valid=%0d level=%0d",
               tag, port, v, l, ev, el);
    end
  endtask

  task automatic pulse_req(input logic [7:0] hw, input logic [7:0] sw);
    hw_req = hw; sw_set = sw;
    tick(1);
    hw_req = '0; sw_set = '0;
  endtask

  task automatic pulse_ack(input bit a1, input bit a2, input bit a3);
    ack1 = a1; ack2 = a2; ack3 = a3;
    tick(1);
    ack1 = 1'b0; ack2 = 1'b0; ack3 = 1'b0;
  endtask

  task automatic t_reset;
    expect_port(1, 0, 0, "R6 reset");
    expect_port(2, 0, 0, "R6 reset");
    expect_port(3, 0, 0, "R6 reset");
  endtask

  task automatic t_single;
    pulse_req(8'h08, 8'h00);
    expect_port(1, 0, 0, "R1 one edge early");
    tick(1);
    expect_port(1, 1, 3, "R1 latch code3");
    expect_port(2, 0, 0, "R3 only one line");
    pulse_ack(1, 0, 0);
    expect_port(1, 0, 0, "R7 ack drops valid");
    tick(2);
    expect_port(1, 0, 0, "R7 pending cleared");
  endtask

  task automatic t_normal_order;
    pulse_req(8'h64, 8'h00);            // codes 2,5,6
    tick(1);
    expect_port(1, 1, 2, "R3 port1 top");
    expect_port(2, 1, 5, "R3 port2 second");
    expect_port(3, 0, 0, "R3 port3 idle");
    pulse_ack(0, 1, 0);
    tick(1);
    expect_port(2, 1, 6, "R3 port2 reload");
    expect_port(1, 1, 2, "R7 other port kept");
    pulse_ack(1, 1, 0);
    tick(2);
    expect_port(1, 0, 0, "R7 all cleared");
    expect_port(2, 0, 0, "R7 all cleared");
  endtask

  task automatic t_survive_order;
    int order[5] = '{5, 6, 3, 4, 2};
    survive = 1'b1;
    pulse_req(8'h7C, 8'h00);            // codes 2..6
    tick(1);
    foreach (order[i]) begin
      expect_port(3, 1, order[i], "R4 survive rank");
      expect_port(1, 0, 0, "R4 port1 only code0");
      expect_port(2, 0, 0, "R4 port2 unused");
      pulse_ack(0, 0, 1);
      tick(1);
    end
    expect_port(3, 0, 0, "R4 drained");
    pulse_req(8'h03, 8'h00);            // codes 0,1
    tick(1);
    expect_port(1, 1, 0, "R4 level1 on port1");
    expect_port(3, 1, 1, "R5 code1 on port3");
    pulse_ack(1, 0, 1);
    survive = 1'b0;
    tick(2);
  endtask

  task automatic t_preempt;
    pulse_req(8'h08, 8'h00);
    tick(1);
    expect_port(1, 1, 3, "R5 before preempt");
    pulse_req(8'h01, 8'h00);
    tick(1);
    expect_port(1, 1, 0, "R5 preempt to code0");
    expect_port(2, 0, 0, "R5 displaced not yet routed");
    tick(1);
    expect_port(2, 1, 3, "R5 displaced line requeued");
    pulse_ack(1, 1, 0);
    tick(2);
    expect_port(1, 0, 0, "R5 cleanup");
    expect_port(2, 0, 0, "R5 cleanup");
  endtask

  task automatic t_mask_spare;
    mask = 8'h10;
    pulse_req(8'h10, 8'h00);
    tick(1);
    expect_port(1, 0, 0, "R2 masked hidden");
    tick(2);
    expect_port(1, 0, 0, "R2 masked still hidden");
    mask = 8'h00;
    tick(1);
    expect_port(1, 1, 4, "R2 unmasked shown");
    pulse_ack(1, 0, 0);
    tick(1);
    pulse_req(8'h82, 8'h00);            // codes 1,7 normal
    tick(1);
    expect_port(1, 1, 1, "R8 normal spare last");
    expect_port(2, 1, 7, "R8 spare on port2");
    pulse_ack(1, 1, 0);
    survive = 1'b1;
    pulse_req(8'hC0, 8'h00);            // codes 6,7 survive
    tick(1);
    expect_port(3, 1, 6, "R8 survive spare last");
    pulse_ack(0, 0, 1);
    tick(1);
    expect_port(3, 1, 7, "R8 spare after code6");
    pulse_ack(0, 0, 1);
    survive = 1'b0;
    tick(2);
  endtask

  task automatic t_mode_change;
    pulse_req(8'h18, 8'h00);            // codes 3,4
    tick(1);
    expect_port(1, 1, 3, "R9 setup");
    expect_port(2, 1, 4, "R9 setup");
    survive = 1'b1;
    pulse_req(8'h20, 8'h00);            // code 5
    tick(1);
    expect_port(1, 1, 3, "R9 port1 kept");
    expect_port(2, 1, 4, "R9 port2 kept");
    expect_port(3, 1, 5, "R9 port3 loads");
    pulse_ack(0, 1, 0);
    tick(1);
    expect_port(2, 0, 0, "R4 port2 no reload in survive");
    pulse_ack(1, 0, 1);
    survive = 1'b0;
    tick(2);
    expect_port(1, 0, 0, "R9 cleanup");
  endtask

  task automatic t_sw_and_ack;
    pulse_req(8'h00, 8'h04);            // software code 2
    tick(1);
    expect_port(1, 1, 2, "R1 software set");
    ack1 = 1'b1; sw_set = 8'h04;        // set and clear on one edge
    tick(1);
    ack1 = 1'b0; sw_set = 8'h00;
    expect_port(1, 0, 0, "R7 ack with set");
    tick(1);
    expect_port(1, 1, 2, "R7 set wins over clear");
    pulse_req(8'h08, 8'h00);
    tick(1);
    expect_port(2, 1, 3, "R3 second line");
    pulse_ack(0, 0, 1);                 // port3 idle
    expect_port(1, 1, 2, "R7 idle ack no effect");
    expect_port(2, 1, 3, "R7 idle ack no effect");
    pulse_ack(1, 1, 0);
    tick(2);
    expect_port(1, 0, 0, "R7 cleanup");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_single();
    t_normal_order();
    t_survive_order();
    t_preempt();
    t_mask_spare();
    t_mode_change();
    t_sw_and_ack();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule